// File: doc/BRIEF.md
# Sticky Status Word with Interrupt Request

This block holds the 16-bit read-only status word of a radio signalling processor and drives the interrupt request behind it. Single-cycle event strobes come in from the tone decoders (selective call, sub-audible tone, digital squelch code), the auxiliary ADC threshold comparators and the MSK modem. The modem also supplies its received rate and sync type. A busy/done handshake comes from the programming engine. Each event sets a sticky bit. A bit stays set until the host reads the word, and that read clears bits 15 down to 1 together.

Bit 0 is a separate handshake flag. It drops when the host writes the programming register and comes back when the programming engine reports completion. The host read does not clear it. Bit 15 is a summary interrupt flag. It is set whenever a status bit sets while that bit's own enable is on. The active-low interrupt pin follows bit 15, gated by a global enable. A power-enable input blanks the read data.

Top module: `sig_status_irq`

## Requirements
- R1: After reset the status word reads 0x0001: only the programming flag (bit 0) is set. The interrupt pin `irq_n` is high.
- R2: In receive mode (`tx_mode`=0), each of the following sets one bit. A selective-call strobe sets bit 13. A sub-audible tone strobe sets bit 11. A squelch-code strobe sets bit 10. Detecting the code turn-off tone also sets bit 10, and so does its removal; neither sets bit 11.
- R3: In transmit mode (`tx_mode`=1), bits 13, 11 and 10 ignore their strobes and read 0. A tone bit that was set in receive mode is cleared once transmit mode takes effect.
- R4: Bit 7 sets only in transmit mode, and only on a last-bit-sent strobe while `msk_end_marker` is 1. In receive mode the strobe has no effect and bit 7 reads 0.
- R5: A data-transfer strobe sets bit 6 in either mode.
- R6: An above-high-threshold strobe sets bit 9 and a below-low-threshold strobe sets bit 8. Both bits can be set at the same time.
- R7: On a frame-valid strobe, `rx_rate` is loaded into bits 4:3 and `rx_sync` into bits 2:1. Rate codes: 01 means 1200 b/s and 10 means 2400 b/s. Sync codes: 01, 10 and 11 are the three sync pattern types.
- R8: A host read (`host_rd` with `power_en`=1) returns the word as it stood before the read. In the next cycle bits 15..1 are 0 and bit 0 is unchanged.
- R9: An event arriving in the same cycle as a clearing read stays set after the read, and so does the interrupt flag it raises.
- R10: A programming-register write clears bit 0 in the next cycle. A `prog_done` strobe sets bit 0 again.
- R11: Bit 15 sets in the cycle after any status bit i sets while `evt_mask[i]`=1. A bit that sets while its mask is 0 still reads 1 but does not raise bit 15.
- R12: `irq_n` is low exactly while bit 15 is 1 and `global_irq_en` is 1.
- R13: While `power_en`=0 the read data is 0x0000. A read made in that state clears nothing.
- R14: Bits 14, 12 and 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| power_en | input | 1 | Read-data enable from power control |
| evt_selcall | input | 1 | Selective-call decoder event strobe |
| evt_ctcss | input | 1 | Sub-audible tone decoder event strobe |
| evt_dcs | input | 1 | Squelch-code decoder event strobe |
| evt_dcs_tail_on | input | 1 | Code turn-off tone detected strobe |
| evt_dcs_tail_gone | input | 1 | Code turn-off tone removed strobe |
| adc_above_hi | input | 1 | ADC went above the high threshold strobe |
| adc_below_lo | input | 1 | ADC went below the low threshold strobe |
| msk_last_sent | input | 1 | Last MSK transmit bit sent strobe |
| msk_end_marker | input | 1 | End marker was set in the transmit data write |
| msk_xfer_req | input | 1 | Modem data-transfer strobe |
| rx_frame_valid | input | 1 | Valid frame sync found strobe |
| rx_rate | input | 2 | Received rate code |
| rx_sync | input | 2 | Received sync type code |
| prog_done | input | 1 | Programming action complete strobe |
| host_rd | input | 1 | Host read of the status word |
| host_wr_prog | input | 1 | Host write to the programming register |
| evt_mask | input | 15 | Per-bit interrupt enables, bit i for status bit i |
| global_irq_en | input | 1 | Global interrupt pin enable |
| status_rdata | output | 16 | Status read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The read-clear property assumes that no event strobe or completion strobe coincides with the read it examines. Coincident events are covered by their own set-wins property instead. The properties also assume every strobe lasts one cycle and that `rx_rate`/`rx_sync` only matter while frame-valid is high. The bench changes every input at the falling edge and pulses each strobe for exactly one cycle. It also keeps all other strobes quiet around its plain reads, and it issues overlapping events only in the scenario that targets that case.

// File: rtl/sig_status_pkg.sv
// Package: bit positions and constant masks of the status word.
// Assumes a fixed 16-bit word; positions are decoded by host software.
package sig_status_pkg;
    localparam int STAT_W     = 16;
    localparam int BANK_W     = STAT_W - 2;   // sticky bits 14..1
    localparam int BIT_IRQ    = 15;
    localparam int BIT_SELC   = 13;
    localparam int BIT_CTCSS  = 11;
    localparam int BIT_DCS    = 10;
    localparam int BIT_ADC_HI = 9;
    localparam int BIT_ADC_LO = 8;
    localparam int BIT_TXEND  = 7;
    localparam int BIT_XFER   = 6;
    localparam int BIT_RATE   = 3;            // 2-bit field 4:3
    localparam int BIT_SYNC   = 1;            // 2-bit field 2:1
    localparam int BIT_PROG   = 0;

    // Reserved positions 14, 12 and 5
    localparam logic [STAT_W-1:0] RSVD_MASK = 16'h5020;
    // Tone bits 13, 11, 10 (forced low in transmit)
    localparam logic [STAT_W-1:0] TONE_MASK = 16'h2C00;
    // Transmit-only bit 7 (forced low in receive)
    localparam logic [STAT_W-1:0] TXEND_MASK = 16'h0080;

    typedef enum logic [1:0] {
        RATE_NONE = 2'b00,
        RATE_1200 = 2'b01,
        RATE_2400 = 2'b10,
        RATE_RSVD = 2'b11
    } rx_rate_e;
endpackage

// File: rtl/sig_status_map.sv
// Module: sig_status_map
// Turns raw event strobes into per-bit set and hold vectors for bits 14..1.
// Assumes strobes last one cycle; mode gating is applied here so the
// sticky bank stays generic.
module sig_status_map
    import sig_status_pkg::*;
(
    input  logic              tx_mode,
    input  logic              evt_selcall,
    input  logic              evt_ctcss,
    input  logic              evt_dcs,
    input  logic              evt_dcs_tail_on,
    input  logic              evt_dcs_tail_gone,
    input  logic              adc_above_hi,
    input  logic              adc_below_lo,
    input  logic              msk_last_sent,
    input  logic              msk_end_marker,
    input  logic              msk_xfer_req,
    input  logic              rx_frame_valid,
    input  logic [1:0]        rx_rate,
    input  logic [1:0]        rx_sync,
    output logic [BANK_W:1]   set_vec,
    output logic [BANK_W:1]   hold_vec
);
    logic [STAT_W-1:0] raw_set;
    logic [STAT_W-1:0] raw_hold;

    // Build the full-width set pattern, then drop reserved and edge bits.
    always_comb begin
        raw_set = '0;
        raw_set[BIT_SELC]   = evt_selcall & ~tx_mode;
        raw_set[BIT_CTCSS]  = evt_ctcss & ~tx_mode;
        raw_set[BIT_DCS]    = (evt_dcs | evt_dcs_tail_on | evt_dcs_tail_gone) & ~tx_mode;
        raw_set[BIT_ADC_HI] = adc_above_hi;
        raw_set[BIT_ADC_LO] = adc_below_lo;
        raw_set[BIT_TXEND]  = tx_mode & msk_last_sent & msk_end_marker;
        raw_set[BIT_XFER]   = msk_xfer_req;
        raw_set[BIT_RATE +: 2] = rx_frame_valid ? rx_rate : RATE_NONE;
        raw_set[BIT_SYNC +: 2] = rx_frame_valid ? rx_sync : 2'b00;
        raw_set = raw_set & ~RSVD_MASK;
    end

    // Bits that the current mode forces to zero.
    always_comb begin
        raw_hold = tx_mode ? TONE_MASK : TXEND_MASK;
    end

    assign set_vec  = raw_set[BANK_W:1];
    assign hold_vec = raw_hold[BANK_W:1];
endmodule

// File: rtl/sig_sticky_bank.sv
// Module: sig_sticky_bank
// A row of sticky bits: set wins over both the clearing read and the
// mode hold, so a coincident event is never lost.
// Assumes clr is already qualified by the read enable.
module sig_sticky_bank #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] hold_vec,
    input  logic         clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit sticky register with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= set_vec[i] | (q[i] & ~clr & ~hold_vec[i]);
        end
    end
endmodule

// File: rtl/sig_prog_flag.sv
// Module: sig_prog_flag
// Programming handshake flag: high when idle, low from a programming
// write until the engine reports done. A write beats a coincident done.
module sig_prog_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_prog,
    input  logic done,
    output logic flag,
    output logic rise
);
    // Flag register; idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b1;
        else if (wr_prog) flag <= 1'b0;
        else if (done)    flag <= 1'b1;
    end

    // Completion that actually changes the flag.
    always_comb begin
        rise = done & ~flag & ~wr_prog;
    end
endmodule

// File: rtl/sig_irq_ctrl.sv
// Module: sig_irq_ctrl
// Summary interrupt flag and pin. Sets on any enabled bit setting; clears
// on a read unless a new enabled event arrives in the same cycle.
module sig_irq_ctrl #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N:1]   set_vec,
    input  logic         prog_rise,
    input  logic [N:0]   mask,
    input  logic         clr,
    input  logic         global_en,
    output logic         irq_flag,
    output logic         irq_n
);
    logic hit;

    // Any enabled bit setting this cycle.
    always_comb begin
        hit = (|(set_vec & mask[N:1])) | (prog_rise & mask[0]);
    end

    // Sticky summary flag with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_flag <= 1'b0;
        else        irq_flag <= hit | (irq_flag & ~clr);
    end

    // Active-low pin gated by the global enable.
    always_comb begin
        irq_n = ~(irq_flag & global_en);
    end
endmodule

// File: rtl/sig_status_irq.sv
// Module: sig_status_irq (top)
// Clear-on-read status word with interrupt request. Reads return the
// word of the current cycle; the clear lands on the next edge.
// Assumes host_rd is a one-cycle strobe per read access.
module sig_status_irq
    import sig_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              power_en,
    input  logic              evt_selcall,
    input  logic              evt_ctcss,
    input  logic              evt_dcs,
    input  logic              evt_dcs_tail_on,
    input  logic              evt_dcs_tail_gone,
    input  logic              adc_above_hi,
    input  logic              adc_below_lo,
    input  logic              msk_last_sent,
    input  logic              msk_end_marker,
    input  logic              msk_xfer_req,
    input  logic              rx_frame_valid,
    input  logic [1:0]        rx_rate,
    input  logic [1:0]        rx_sync,
    input  logic              prog_done,
    input  logic              host_rd,
    input  logic              host_wr_prog,
    input  logic [STAT_W-2:0] evt_mask,
    input  logic              global_irq_en,
    output logic [STAT_W-1:0] status_rdata,
    output logic              irq_n
);
    logic [BANK_W:1]   set_vec;
    logic [BANK_W:1]   hold_vec;
    logic [BANK_W-1:0] bank_q;
    logic              read_clr;
    logic              prog_q;
    logic              prog_rise;
    logic              irq_flag;
    logic [STAT_W-1:0] stat_word;

    // A read only counts while the word is visible.
    always_comb begin
        read_clr = host_rd & power_en;
    end

    sig_status_map u_map (
        .tx_mode           (tx_mode),
        .evt_selcall       (evt_selcall),
        .evt_ctcss         (evt_ctcss),
        .evt_dcs           (evt_dcs),
        .evt_dcs_tail_on   (evt_dcs_tail_on),
        .evt_dcs_tail_gone (evt_dcs_tail_gone),
        .adc_above_hi      (adc_above_hi),
        .adc_below_lo      (adc_below_lo),
        .msk_last_sent     (msk_last_sent),
        .msk_end_marker    (msk_end_marker),
        .msk_xfer_req      (msk_xfer_req),
        .rx_frame_valid    (rx_frame_valid),
        .rx_rate           (rx_rate),
        .rx_sync           (rx_sync),
        .set_vec           (set_vec),
        .hold_vec          (hold_vec)
    );

    sig_sticky_bank #(.N(BANK_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .hold_vec (hold_vec),
        .clr      (read_clr),
        .q        (bank_q)
    );

    sig_prog_flag u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_prog (host_wr_prog),
        .done    (prog_done),
        .flag    (prog_q),
        .rise    (prog_rise)
    );

    sig_irq_ctrl #(.N(BANK_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .prog_rise (prog_rise),
        .mask      (evt_mask),
        .clr       (read_clr),
        .global_en (global_irq_en),
        .irq_flag  (irq_flag),
        .irq_n     (irq_n)
    );

    // Assemble the word and blank it when power is off.
    always_comb begin
        stat_word    = {irq_flag, bank_q, prog_q};
        status_rdata = power_en ? stat_word : '0;
    end
endmodule

// File: rtl/sig_status_irq_chk.sv
// Module: sig_status_irq_chk
// Temporal checks on the status word, bound into the top module.
module sig_status_irq_chk
    import sig_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tx_mode,
    input logic              power_en,
    input logic              host_rd,
    input logic              host_wr_prog,
    input logic              global_irq_en,
    input logic              irq_n,
    input logic              any_evt,
    input logic              evt_selcall,
    input logic [STAT_W-2:0] evt_mask,
    input logic [STAT_W-1:0] stat_word
);
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && power_en && !any_evt) |=> (stat_word[STAT_W-1:1] == '0)); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_selcall && !tx_mode) |=> stat_word[BIT_SELC]); // R9

    AST_PROG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_prog |=> !stat_word[BIT_PROG]); // R10

    AST_TX_TONES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && $past(tx_mode)) |-> ((stat_word & TONE_MASK) == '0)); // R3

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_word[BIT_IRQ]) |-> $past(|evt_mask)); // R11

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !global_irq_en |-> irq_n); // R12
endmodule

bind sig_status_irq sig_status_irq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_mode       (tx_mode),
    .power_en      (power_en),
    .host_rd       (host_rd),
    .host_wr_prog  (host_wr_prog),
    .global_irq_en (global_irq_en),
    .irq_n         (irq_n),
    .any_evt       (evt_selcall | evt_ctcss | evt_dcs | evt_dcs_tail_on |
                    evt_dcs_tail_gone | adc_above_hi | adc_below_lo |
                    msk_last_sent | msk_xfer_req | rx_frame_valid | prog_done),
    .evt_selcall   (evt_selcall),
    .evt_mask      (evt_mask),
    .stat_word     (stat_word)
);

// File: tb/tb_sig_status_irq.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; inputs change on falling edges.
module tb_sig_status_irq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_mode, power_en;
    logic        evt_selcall, evt_ctcss, evt_dcs, evt_dcs_tail_on, evt_dcs_tail_gone;
    logic        adc_above_hi, adc_below_lo, msk_last_sent, msk_end_marker, msk_xfer_req;
    logic        rx_frame_valid, prog_done, host_rd, host_wr_prog, global_irq_en;
    logic [1:0]  rx_rate, rx_sync;
    logic [14:0] evt_mask;
    logic [15:0] status_rdata;
    logic        irq_n;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    localparam int K_SELC = 0, K_CTC = 1, K_DCS = 2, K_TON = 3, K_TOFF = 4,
                   K_AHI = 5, K_ALO = 6, K_TXE = 7, K_TXE_NM = 8, K_XFR = 9,
                   K_PDONE = 10;

    always #2.5 clk = ~clk;

    sig_status_irq dut (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .power_en(power_en),
        .evt_selcall(evt_selcall), .evt_ctcss(evt_ctcss), .evt_dcs(evt_dcs),
        .evt_dcs_tail_on(evt_dcs_tail_on), .evt_dcs_tail_gone(evt_dcs_tail_gone),
        .adc_above_hi(adc_above_hi), .adc_below_lo(adc_below_lo),
        .msk_last_sent(msk_last_sent), .msk_end_marker(msk_end_marker),
        .msk_xfer_req(msk_xfer_req), .rx_frame_valid(rx_frame_valid),
        .rx_rate(rx_rate), .rx_sync(rx_sync), .prog_done(prog_done),
        .host_rd(host_rd), .host_wr_prog(host_wr_prog), .evt_mask(evt_mask),
        .global_irq_en(global_irq_en), .status_rdata(status_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        evt_selcall = 0; evt_ctcss = 0; evt_dcs = 0; evt_dcs_tail_on = 0;
        evt_dcs_tail_gone = 0; adc_above_hi = 0; adc_below_lo = 0;
        msk_last_sent = 0; msk_end_marker = 0; msk_xfer_req = 0;
        rx_frame_valid = 0; rx_rate = 0; rx_sync = 0; prog_done = 0;
        host_rd = 0; host_wr_prog = 0;
    endtask

    task automatic peek(input string req, input logic [15:0] exp, input logic exp_irqn);
        #1;
        chk(req, status_rdata, exp);
        chk({req, " irq_n"}, {15'd0, irq_n}, {15'd0, exp_irqn});
    endtask

    task automatic fire(input int kind);
        case (kind)
            K_SELC:   evt_selcall = 1;
            K_CTC:    evt_ctcss = 1;
            K_DCS:    evt_dcs = 1;
            K_TON:    evt_dcs_tail_on = 1;
            K_TOFF:   evt_dcs_tail_gone = 1;
            K_AHI:    adc_above_hi = 1;
            K_ALO:    adc_below_lo = 1;
            K_TXE:    begin msk_last_sent = 1; msk_end_marker = 1; end
            K_TXE_NM: msk_last_sent = 1;
            K_XFR:    msk_xfer_req = 1;
            default:  prog_done = 1;
        endcase
        step();
        quiet();
    endtask

    task automatic frame(input logic [1:0] rate, input logic [1:0] sync);
        rx_frame_valid = 1; rx_rate = rate; rx_sync = sync;
        step();
        quiet();
    endtask

    task automatic rd_clear(output logic [15:0] v);
        host_rd = 1;
        #1 v = status_rdata;
        @(posedge clk);
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic t_reset();
        peek("R1 reset", 16'h0001, 1'b1);
    endtask

    task automatic t_tones();
        logic [15:0] v;
        fire(K_SELC);  peek("R2 selcall", 16'hA001, 1'b0);
        rd_clear(v);   chk("R8 read value", v, 16'hA001);
        peek("R8 after read", 16'h0001, 1'b1);
        fire(K_CTC);   peek("R2 ctcss", 16'h8801, 1'b0); rd_clear(v);
        fire(K_DCS);   peek("R2 dcs", 16'h8401, 1'b0);   rd_clear(v);
        fire(K_TON);   peek("R2 tail on", 16'h8401, 1'b0); rd_clear(v);
        fire(K_TOFF);  peek("R2 tail gone", 16'h8401, 1'b0); rd_clear(v);
    endtask

    task automatic t_tx();
        logic [15:0] v;
        fire(K_SELC);
        tx_mode = 1; step();
        peek("R3 tone dropped in tx", 16'h8001, 1'b0);
        rd_clear(v);
        fire(K_SELC); fire(K_CTC); fire(K_DCS); fire(K_TOFF);
        peek("R3 tones ignored in tx", 16'h0001, 1'b1);
        tx_mode = 0; step();
    endtask

    task automatic t_txend();
        logic [15:0] v;
        tx_mode = 1; step();
        fire(K_TXE_NM); peek("R4 no marker", 16'h0001, 1'b1);
        fire(K_TXE);    peek("R4 tx end", 16'h8081, 1'b0);
        rd_clear(v);
        tx_mode = 0; step();
        fire(K_TXE);    peek("R4 rx ignores", 16'h0001, 1'b1);
    endtask

    task automatic t_xfer();
        logic [15:0] v;
        fire(K_XFR); peek("R5 rx xfer", 16'h8041, 1'b0); rd_clear(v);
        tx_mode = 1; step();
        fire(K_XFR); peek("R5 tx xfer", 16'h8041, 1'b0); rd_clear(v);
        tx_mode = 0; step();
    endtask

    task automatic t_adc();
        logic [15:0] v;
        fire(K_AHI); peek("R6 above", 16'h8201, 1'b0);
        fire(K_ALO); peek("R6 both", 16'h8301, 1'b0); rd_clear(v);
        fire(K_ALO); peek("R6 below", 16'h8101, 1'b0); rd_clear(v);
    endtask

    task automatic t_frame();
        logic [15:0] v;
        frame(2'b01, 2'b01); peek("R7 1200 sync1", 16'h800B, 1'b0); rd_clear(v);
        frame(2'b10, 2'b11); peek("R7 2400 sync3", 16'h8017, 1'b0); rd_clear(v);
        frame(2'b01, 2'b10); peek("R7 1200 sync2", 16'h800D, 1'b0); rd_clear(v);
    endtask

    task automatic t_set_wins();
        logic [15:0] v;
        fire(K_AHI);
        host_rd = 1; evt_selcall = 1;
        #1 v = status_rdata;
        step();
        quiet();
        chk("R9 read value", v, 16'h8201);
        peek("R9 event kept", 16'hA001, 1'b0);
        rd_clear(v);
    endtask

    task automatic t_prog();
        logic [15:0] v;
        host_wr_prog = 1; step(); quiet();
        peek("R10 write clears", 16'h0000, 1'b1);
        rd_clear(v);
        peek("R10 read keeps bit0", 16'h0000, 1'b1);
        fire(K_PDONE);
        peek("R10 done restores", 16'h8001, 1'b0);
        rd_clear(v);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        evt_mask = 15'h0000;
        fire(K_SELC); peek("R11 masked", 16'h2001, 1'b1); rd_clear(v);
        evt_mask = 15'h0800;
        fire(K_SELC); peek("R11 other masked", 16'h2001, 1'b1);
        fire(K_CTC);  peek("R11 enabled bit", 16'hA801, 1'b0); rd_clear(v);
        evt_mask = 15'h7FFF;
        global_irq_en = 0;
        fire(K_SELC); peek("R12 pin gated", 16'hA001, 1'b1);
        global_irq_en = 1;
        #1 chk("R12 pin on", {15'd0, irq_n}, 16'h0000);
        rd_clear(v);
    endtask

    task automatic t_power();
        logic [15:0] v;
        fire(K_SELC);
        power_en = 0;
        peek("R13 blank", 16'h0000, 1'b0);
        rd_clear(v);
        chk("R13 read value", v, 16'h0000);
        power_en = 1;
        peek("R13 nothing cleared", 16'hA001, 1'b0);
        rd_clear(v);
    endtask

    task automatic t_all();
        logic [15:0] v;
        evt_selcall = 1; evt_ctcss = 1; evt_dcs = 1; adc_above_hi = 1;
        adc_below_lo = 1; msk_xfer_req = 1; rx_frame_valid = 1;
        rx_rate = 2'b11; rx_sync = 2'b11;
        step(); quiet();
        peek("R14 reserved zero", 16'hAF5F, 1'b0);
        rd_clear(v);
    endtask

    initial begin
        rst_n = 0; tx_mode = 0; power_en = 1; evt_mask = 15'h7FFF;
        global_irq_en = 1;
        quiet();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_tones();
        t_tx();
        t_txend();
        t_xfer();
        t_adc();
        t_frame();
        t_set_wins();
        t_prog();
        t_mask();
        t_power();
        t_all();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule